// File: doc/BRIEF.md
# Service Request Mailbox

This block is a register-mapped mailbox that lets a host hand a service request to a separate controller on the same clock. The host writes a control word holding a command code and three control bits (request, abort, notify). While request is set, the command is offered to the controller. The controller takes the command with a one-cycle accept strobe, works on it, and ends with a one-cycle done strobe that carries a completion status.

The host sees progress through two words on a simple write-strobe and address bus with combinational read data. The control word shows the command and the four control bits, including a read-only busy flag. The status word holds the returned status code and a copy of the four control bits. The status code reads as zero while a service is in progress, because it is only meaningful once busy has dropped. If notify was set, a one-cycle interrupt pulse marks the end of the service.

Top module: `svc_mailbox`

## Requirements
- R1: After reset, both words read 0, and ctl_req, ctl_abort and irq are 0.
- R2: The control word (word index 0) reads as the command in bits [31:16], notify in bit 3, abort in bit 2, busy in bit 1 and request in bit 0. All other bits read 0. Writes to the busy bit have no effect.
- R3: A write of 1 to bit 0 of the control word while request and busy are both 0 sets request. ctl_req then follows request and ctl_cmd shows the stored command. Request stays set until the controller pulses ctl_accept.
- R4: ctl_accept while request is set clears request and sets busy on the same clock edge. Busy stays set until ctl_done, which clears it. Request and busy are never both set.
- R5: While request or busy is set, writes change neither the command field nor request. Notify stays writable at all times.
- R6: The status word (word index 1) reads as the status captured at ctl_done in bits [31:16], forced to 0 while busy is 1. Bits [3:0] copy notify, abort, busy and request in control-word positions. All other bits read 0.
- R7: A write of 1 to bit 2 while request or busy is set sets abort, which drives ctl_abort. Abort clears when the service ends. The same write while idle is ignored.
- R8: When ctl_done ends a service while notify is 1, irq is high for exactly one cycle: the first cycle in which busy reads 0. With notify at 0, irq stays low.
- R9: Word indices other than 0 and 1 read 0. Writes to any index other than 0, including the status word, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and controller |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host word index |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| ctl_req | output | 1 | A command is waiting to be accepted |
| ctl_cmd | output | CMD_W | Command code offered to the controller |
| ctl_abort | output | 1 | Host asked for the service to be aborted |
| ctl_accept | input | 1 | Controller takes the pending command |
| ctl_done | input | 1 | Controller finished the current service |
| ctl_status | input | STAT_W | Completion status, sampled with ctl_done |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench uses the defaults CMD_W=16, STAT_W=16 and ADDR_W=2. The two-bit index makes the whole address space, both decoded words and the two unused slots, small enough to sweep completely. All sixteen combinations of the four low control-word bits are written from idle, and each request is driven through accept and done. Abort is applied both before and after accept. A walking-one sweep over the 16-bit command and status fields checks every field bit in place, with expected words built arithmetically.

// File: rtl/mbx_pkg.sv
// Package: shared field positions and the control-bit bundle of the mailbox.
// Assumes a 32-bit host word with codes in the upper half.
package mbx_pkg;
    localparam int WORD_W     = 32;
    localparam int FIELD_LSB  = 16;
    localparam int FIELD_MAXW = WORD_W - FIELD_LSB;
    localparam int BIT_REQ    = 0;
    localparam int BIT_BUSY   = 1;
    localparam int BIT_ABORT  = 2;
    localparam int BIT_NOTIFY = 3;

    typedef struct packed {
        logic notify;
        logic abort;
        logic busy;
        logic request;
    } ctl_bits_t;
endpackage

// File: rtl/mbx_ctrl_regs.sv
// Module: control state of the mailbox (command, request, busy, abort, notify
// and captured status). Assumes accept and done are one-cycle strobes from the
// controller; accept is honoured only while request is set, done only while busy.
module mbx_ctrl_regs
    import mbx_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ctl_accept,
    input  logic              ctl_done,
    input  logic [STAT_W-1:0] ctl_status,
    output ctl_bits_t         bits,
    output logic [CMD_W-1:0]  cmd,
    output logic [STAT_W-1:0] status
);
    logic pending;
    logic take;
    logic finish;

    assign pending = bits.request | bits.busy;
    assign take    = bits.request & ctl_accept;
    assign finish  = bits.busy & ctl_done;

    // Command field: loaded by host writes only while no service is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmd <= '0;
        else if (wr_ctl && !pending) cmd <= wdata[FIELD_LSB +: CMD_W];
    end

    // Notify: freely writable by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      bits.notify <= 1'b0;
        else if (wr_ctl) bits.notify <= wdata[BIT_NOTIFY];
    end

    // Request: set by host from idle, cleared when the controller accepts.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       bits.request <= 1'b0;
        else if (take)                                    bits.request <= 1'b0;
        else if (wr_ctl && !pending && wdata[BIT_REQ])    bits.request <= 1'b1;
    end

    // Busy: spans from accept to done.
    always_ff @(posedge clk) begin
        if (!rst_n)      bits.busy <= 1'b0;
        else if (take)   bits.busy <= 1'b1;
        else if (finish) bits.busy <= 1'b0;
    end

    // Abort: raised by host only while a service is pending, dropped at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     bits.abort <= 1'b0;
        else if (finish)                                bits.abort <= 1'b0;
        else if (wr_ctl && pending && wdata[BIT_ABORT]) bits.abort <= 1'b1;
    end

    // Status: captured from the controller when the service ends.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= '0;
        else if (finish) status <= ctl_status;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits.request && !ctl_accept |=> bits.request);
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits.busy && !ctl_done |=> bits.busy);
    // R4
    req_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bits.request && bits.busy));
    // R5
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bits.request || bits.busy) |=> $stable(cmd));
    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bits.request || bits.busy) |-> !bits.abort);
endmodule

// File: rtl/mbx_irq_gen.sv
// Module: completion interrupt. Emits a one-cycle pulse on the falling edge of
// busy when notify is set. Assumes busy and notify come from registers.
module mbx_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic notify,
    output logic irq
);
    logic busy_prev;

    // Remember last cycle's busy to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_prev <= 1'b0;
        else        busy_prev <= busy;
    end

    assign irq = busy_prev & ~busy & notify;

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/mbx_read_mux.sv
// Module: host read path. Builds the control and status words and selects one
// by word index; unused indices read zero. Purely combinational.
module mbx_read_mux
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CMD_W    = 16,
    parameter int STAT_W   = 16,
    parameter int CTL_IDX  = 0,
    parameter int STAT_IDX = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctl_bits_t         bits,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [STAT_W-1:0] status,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] stat_word;

    // Assemble both words with reserved bits at zero; hide status while busy.
    always_comb begin
        ctl_word  = '0;
        stat_word = '0;
        ctl_word[FIELD_LSB +: CMD_W] = cmd;
        ctl_word[3:0]                = bits;
        stat_word[FIELD_LSB +: STAT_W] = bits.busy ? '0 : status;
        stat_word[3:0]                 = bits;
    end

    // Select the addressed word.
    always_comb begin
        if (addr == ADDR_W'(CTL_IDX))       rdata = ctl_word;
        else if (addr == ADDR_W'(STAT_IDX)) rdata = stat_word;
        else                                rdata = '0;
    end
endmodule

// File: rtl/svc_mailbox.sv
// Module: service request mailbox top. Decodes host writes, ties the control
// registers, read path and interrupt generator together. Assumes one shared
// clock and a host bus with a single-cycle write strobe.
module svc_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CMD_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctl_req,
    output logic [CMD_W-1:0]  ctl_cmd,
    output logic              ctl_abort,
    input  logic              ctl_accept,
    input  logic              ctl_done,
    input  logic [STAT_W-1:0] ctl_status,
    output logic              irq
);
    localparam int CTL_IDX  = 0;
    localparam int STAT_IDX = 1;

    ctl_bits_t         bits;
    logic [STAT_W-1:0] status;
    logic              wr_ctl;

    assign wr_ctl    = bus_wr && (bus_addr == ADDR_W'(CTL_IDX));
    assign ctl_req   = bits.request;
    assign ctl_abort = bits.abort;

    mbx_ctrl_regs #(.CMD_W(CMD_W), .STAT_W(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(bus_wdata),
        .ctl_accept(ctl_accept), .ctl_done(ctl_done), .ctl_status(ctl_status),
        .bits(bits), .cmd(ctl_cmd), .status(status)
    );

    mbx_read_mux #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .STAT_W(STAT_W),
                   .CTL_IDX(CTL_IDX), .STAT_IDX(STAT_IDX)) u_rd (
        .addr(bus_addr), .bits(bits), .cmd(ctl_cmd), .status(status),
        .rdata(bus_rdata)
    );

    mbx_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .busy(bits.busy), .notify(bits.notify),
        .irq(irq)
    );

    // R8
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_done && bits.busy && bits.notify |=> irq);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !bits.busy && !bits.request);
endmodule

// File: tb/svc_mailbox_test.sv
module svc_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ctl_req, ctl_abort, irq;
    logic [15:0] ctl_cmd;
    logic        ctl_accept = 1'b0;
    logic        ctl_done = 1'b0;
    logic [15:0] ctl_status = '0;

    int vectors = 0;
    int errs = 0;

    // expected model state
    logic [15:0] e_cmd = '0;
    logic [15:0] e_stat = '0;
    logic e_n = 0, e_a = 0, e_b = 0, e_r = 0;

    svc_mailbox uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_req(ctl_req),
        .ctl_cmd(ctl_cmd), .ctl_abort(ctl_abort), .ctl_accept(ctl_accept),
        .ctl_done(ctl_done), .ctl_status(ctl_status), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] ctl_exp();
        return {e_cmd, 12'h000, e_n, e_a, e_b, e_r};
    endfunction

    function automatic logic [31:0] stat_exp();
        return {(e_b ? 16'h0000 : e_stat), 12'h000, e_n, e_a, e_b, e_r};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_words(input string tag);
        logic [31:0] d;
        rd(2'd0, d); chk({tag, " R2 ctl word"}, d, ctl_exp());
        rd(2'd1, d); chk({tag, " R6 status word"}, d, stat_exp());
        chk({tag, " R3 ctl_req/cmd"}, {15'd0, ctl_req, ctl_cmd}, {15'd0, e_r, e_cmd});
        chk({tag, " R7 ctl_abort"}, {31'd0, ctl_abort}, {31'd0, e_a});
    endtask

    task automatic accept_it();
        @(negedge clk); ctl_accept = 1'b1;
        @(negedge clk); ctl_accept = 1'b0;
        e_r = 0; e_b = 1;
    endtask

    // completes the service and checks the interrupt pulse (R8)
    task automatic finish_it(input logic [15:0] s, input string tag);
        @(negedge clk); ctl_done = 1'b1; ctl_status = s;
        @(negedge clk); ctl_done = 1'b0;
        e_b = 0; e_a = 0; e_stat = s;
        chk({tag, " R8 irq pulse"}, {31'd0, irq}, {31'd0, e_n});
        check_words(tag);
        @(negedge clk);
        chk({tag, " R8 irq single cycle"}, {31'd0, irq}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R9 unused slots
        check_words("reset R1");
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R1 R9 read after reset", d, 32'd0);
        end

        // idle sweep of all 16 low-bit patterns
        for (int i = 0; i < 16; i++) begin
            logic [15:0] c;
            logic [3:0]  p;
            c = 16'hA5C3 ^ 16'(i * 32'h1357);
            p = 4'(i);
            wr(2'd0, {c, 12'hFFF, p});
            e_cmd = c; e_n = p[3]; e_r = p[0]; // busy ignored, abort ignored when idle
            check_words("sweep R2 R7");
            if (p[0]) begin
                repeat (3) @(negedge clk);
                check_words("sweep R3 hold");
                wr(2'd0, {~c, 12'h000, e_n, 3'b001});   // R5 ignored while pending
                check_words("sweep R5 pending");
                accept_it();
                check_words("sweep R4 busy");
                wr(2'd0, {c ^ 16'h00FF, 12'h000, e_n, 3'b001}); // R5 ignored while busy
                check_words("sweep R5 busy");
                if (p[1]) begin
                    wr(2'd0, {16'h0, 12'h000, e_n, 3'b100});
                    e_a = 1;
                    check_words("sweep R7 abort busy");
                end
                repeat (2) @(negedge clk);
                check_words("sweep R4 busy hold");
                finish_it(~c, "sweep");
            end else begin
                chk("sweep R8 no irq", {31'd0, irq}, 32'd0);
            end
            // R9: status word and unused slots are not writable
            wr(2'd1, 32'hFFFF_FFFF);
            wr(2'd2, 32'hFFFF_FFFF);
            check_words("sweep R9 ignored");
            rd(2'd2, d); chk("R9 slot2", d, 32'd0);
            rd(2'd3, d); chk("R9 slot3", d, 32'd0);
        end

        // abort before accept (R7), notify off (R8 stays low)
        wr(2'd0, {16'h1234, 12'h000, 4'b0001});
        e_cmd = 16'h1234; e_n = 0; e_r = 1;
        wr(2'd0, {16'h1234, 12'h000, 4'b0100});
        e_a = 1;
        check_words("R7 abort pending");
        accept_it();
        check_words("R7 abort kept");
        finish_it(16'hBEEF, "R7 abort end");

        // walking-one sweep of command and status fields, notify on
        for (int b = 0; b < 16; b++) begin
            logic [15:0] c;
            c = 16'h0001 << b;
            wr(2'd0, {c, 12'h000, 4'b1001});
            e_cmd = c; e_n = 1; e_r = 1;
            check_words("walk R3");
            accept_it();
            check_words("walk R6 masked");
            finish_it(16'h8000 >> b, "walk R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule